// File: doc/BRIEF.md
# I2C SCL Period Generator

This block sets the bit timing of an I2C master. A nine-bit configuration word holds a prescale field, which divides the system clock down to an internal reference rate, and a gap field, which sets how many reference periods one SCL period lasts. The generator emits a reference-rate enable. It also emits the SCL level and three single-cycle strobes that a bit engine uses: a mid-low strobe for changing SDA, a mid-high strobe for sampling SDA, and an end-of-period strobe.

One SCL period lasts 20 + 8×gap + F reference periods. F is a fixed compensation count, set by a parameter, that covers the bus fall time, the rise time and the internal delay. The base count 20 + 8×gap is split evenly between the low and the high phase, and F is added to the high phase, so the measured high time includes the rise allowance. A new configuration word is taken only at the end of an SCL period or while the generator is stopped, so a period in progress is never cut short or stretched.

Top module: `sclTimingGen`

## Requirements
- R1: The prescale field is cfgWord[2:0] (value d). While enable is high, refTick pulses for one cycle once every d+1 system clocks, so division ratios run from 1 to 8.
- R2: The gap field is cfgWord[8:3] (value g). One SCL period spans P = 20 + 8g + F reference ticks (F = COMP_CYCLES, default 5). periodEnd pulses on the last reference tick of each period, so consecutive periodEnd pulses are P×(d+1) system clocks apart.
- R3: Each period begins with sclOut low for 10 + 4g reference periods.
- R4: After the low phase, sclOut stays high for 10 + 4g + F reference periods, and it rises only just after a reference tick.
- R5: Ticks are numbered from 0 at the start of the period. midLowTick pulses on tick 5 + 2g, while sclOut is low. midHighTick pulses on tick (10 + 4g) + floor((10 + 4g + F)/2), while sclOut is high.
- R6: A change of cfgWord while enable is high has no effect on the period in progress. The new prescale and gap values take effect from the period that follows the next periodEnd.
- R7: While enable is low, sclOut is high, no strobe or refTick is produced, the counters are cleared, and the configuration follows cfgWord. The first period after enable rises uses the word present in the last idle cycle.
- R8: After reset, with enable low, sclOut is high and refTick, midLowTick, midHighTick and periodEnd are all low.
- R9: midLowTick, midHighTick and periodEnd never pulse together, and each pulses only in a cycle where refTick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the generator; low holds it idle |
| cfgWord | input | 9 | Configuration: [2:0] prescale, [8:3] gap |
| refTick | output | 1 | Internal reference-rate enable |
| sclOut | output | 1 | SCL level to drive (1 = released high) |
| midLowTick | output | 1 | Strobe in the middle of the low phase |
| midHighTick | output | 1 | Strobe in the middle of the high phase |
| periodEnd | output | 1 | Strobe on the last tick of a period |

## Verification
The assertions check on every cycle that the strobes exclude one another, that each strobe coincides with a reference tick, that the strobe levels agree with the SCL level, that SCL rises only after a tick and is low just after a period ends, and that the idle state is quiet. Exact period, phase lengths and strobe positions for given prescale and gap values can only be shown by the bench. The same holds for a configuration change being deferred to the period boundary, and for the word loaded during idle. The bench shows these through its per-cycle reference model and through measured distances in system clocks.

// File: rtl/sclTimingPkg.sv
package sclTimingPkg;
  // Strobes from the control half to the counting datapath.
  typedef struct packed {
    logic run;      // counters advance; low clears them
    logic loadCfg;  // capture a new configuration word
  } sclCtrl_t;
endpackage

// File: rtl/sclTimingCtrl.sv
module sclTimingCtrl
  import sclTimingPkg::*;
(
  input  logic     enable,
  input  logic     periodEnd,
  output sclCtrl_t ctrl
);
  // Configuration is accepted only at a period boundary or while idle.
  always_comb begin
    ctrl.run     = enable;
    ctrl.loadCfg = !enable || periodEnd;
  end
endmodule

// File: rtl/sclTimingPath.sv
module sclTimingPath
  import sclTimingPkg::*;
#(
  parameter int PRE_W       = 3,
  parameter int GAP_W       = 6,
  parameter int COMP_CYCLES = 5,
  parameter int CNT_W       = 10
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [PRE_W+GAP_W-1:0] cfgWord,
  input  sclCtrl_t               ctrl,
  output logic                   refTick,
  output logic                   periodEnd,
  output logic                   sclOut,
  output logic                   midLowTick,
  output logic                   midHighTick
);
  localparam int CFG_W = PRE_W + GAP_W;

  logic [PRE_W-1:0] divQ;
  logic [GAP_W-1:0] gapQ;
  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] phaseCnt;

  logic [CNT_W-1:0] lowLen;
  logic [CNT_W-1:0] highLen;
  logic [CNT_W-1:0] lastIdx;
  logic [CNT_W-1:0] midLowIdx;
  logic [CNT_W-1:0] midHighIdx;

  always_comb begin
    lowLen     = CNT_W'(10) + (CNT_W'(gapQ) << 2);
    highLen    = lowLen + CNT_W'(COMP_CYCLES);
    lastIdx    = lowLen + highLen - CNT_W'(1);
    midLowIdx  = lowLen >> 1;
    midHighIdx = lowLen + (highLen >> 1);
  end

  assign refTick     = ctrl.run && (preCnt == divQ);
  assign periodEnd   = refTick && (phaseCnt == lastIdx);
  assign midLowTick  = refTick && (phaseCnt == midLowIdx);
  assign midHighTick = refTick && (phaseCnt == midHighIdx);
  assign sclOut      = !ctrl.run || (phaseCnt >= lowLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ <= '0;
      gapQ <= '0;
    end else if (ctrl.loadCfg) begin
      divQ <= cfgWord[PRE_W-1:0];
      gapQ <= cfgWord[CFG_W-1:PRE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt   <= '0;
      phaseCnt <= '0;
    end else if (!ctrl.run) begin
      preCnt   <= '0;
      phaseCnt <= '0;
    end else if (refTick) begin
      preCnt   <= '0;
      phaseCnt <= periodEnd ? '0 : phaseCnt + CNT_W'(1);
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end
endmodule

// File: rtl/sclTimingGen.sv
module sclTimingGen
  import sclTimingPkg::*;
#(
  parameter int PRE_W       = 3,
  parameter int GAP_W       = 6,
  parameter int COMP_CYCLES = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   enable,
  input  logic [PRE_W+GAP_W-1:0] cfgWord,
  output logic                   refTick,
  output logic                   sclOut,
  output logic                   midLowTick,
  output logic                   midHighTick,
  output logic                   periodEnd
);
  localparam int MAX_PERIOD = 20 + 8 * ((1 << GAP_W) - 1) + COMP_CYCLES;
  localparam int CNT_W      = $clog2(MAX_PERIOD + 1);

  sclCtrl_t ctrl;

  sclTimingCtrl u_ctrl (
    .enable   (enable),
    .periodEnd(periodEnd),
    .ctrl     (ctrl)
  );

  sclTimingPath #(
    .PRE_W      (PRE_W),
    .GAP_W      (GAP_W),
    .COMP_CYCLES(COMP_CYCLES),
    .CNT_W      (CNT_W)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWord    (cfgWord),
    .ctrl       (ctrl),
    .refTick    (refTick),
    .periodEnd  (periodEnd),
    .sclOut     (sclOut),
    .midLowTick (midLowTick),
    .midHighTick(midHighTick)
  );
endmodule

// File: rtl/sclTimingChk.sv
module sclTimingChk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic refTick,
  input logic sclOut,
  input logic midLowTick,
  input logic midHighTick,
  input logic periodEnd
);
  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({midLowTick, midHighTick, periodEnd}));

  // R9
  strobe_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (midLowTick || midHighTick || periodEnd) |-> refTick);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (sclOut && !refTick && !midLowTick && !midHighTick && !periodEnd));

  // R3
  low_after_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodEnd |=> (!enable || !sclOut));

  // R5
  mid_low_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    midLowTick |-> !sclOut);

  // R5
  mid_high_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    midHighTick |-> sclOut);

  // R4
  rise_after_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && $rose(sclOut)) |-> $past(refTick));
endmodule

bind sclTimingGen sclTimingChk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .refTick    (refTick),
  .sclOut     (sclOut),
  .midLowTick (midLowTick),
  .midHighTick(midHighTick),
  .periodEnd  (periodEnd)
);

// File: tb/sclTimingGen_tb.sv
module sclTimingGen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int COMP       = 5;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [8:0] cfgWord = '0;
  logic       refTick, sclOut, midLowTick, midHighTick, periodEnd;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  sclTimingGen u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWord(cfgWord),
    .refTick(refTick), .sclOut(sclOut), .midLowTick(midLowTick),
    .midHighTick(midHighTick), .periodEnd(periodEnd)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Behavioural reference model
  int mPre = 0, mPhase = 0, mDiv = 0, mGap = 0;

  function automatic int periodOf(int g);
    return 20 + 8 * g + COMP;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPre = 0; mPhase = 0; mDiv = 0; mGap = 0;
    end else if (!enable) begin
      mPre = 0; mPhase = 0;
      mDiv = int'(cfgWord[2:0]); mGap = int'(cfgWord[8:3]);
    end else if (mPre == mDiv) begin
      mPre = 0;
      if (mPhase == periodOf(mGap) - 1) begin
        mPhase = 0;
        mDiv = int'(cfgWord[2:0]); mGap = int'(cfgWord[8:3]);
      end else begin
        mPhase++;
      end
    end else begin
      mPre++;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      int lowL, highL;
      bit t;
      lowL  = 10 + 4 * mGap;
      highL = lowL + COMP;
      t     = enable && (mPre == mDiv);
      check("R1 refTick", int'(refTick), int'(t));
      check("R3/R4/R7 sclOut", int'(sclOut), int'(!enable || mPhase >= lowL));
      check("R5 midLowTick", int'(midLowTick), int'(t && mPhase == lowL / 2));
      check("R5 midHighTick", int'(midHighTick), int'(t && mPhase == lowL + highL / 2));
      check("R2 periodEnd", int'(periodEnd), int'(t && mPhase == lowL + highL - 1));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic drive(bit en, logic [8:0] w);
    @(posedge clk); #1;
    enable = en; cfgWord = w;
  endtask

  task automatic waitEnd();
    do @(negedge clk); while (!periodEnd);
  endtask

  // System clocks from the current point to the next periodEnd
  task automatic toNextEnd(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!periodEnd);
  endtask

  function automatic logic [8:0] mk(int d, int g);
    return {6'(g), 3'(d)};
  endfunction

  task automatic measurePeriod(int d, int g, string tag);
    int n;
    waitEnd();
    toNextEnd(n);
    check(tag, n, periodOf(g) * (d + 1));
  endtask

  task automatic measurePhases(int d, int g);
    int lo, hi;
    waitEnd();
    lo = 0; hi = 0;
    @(negedge clk);
    while (!sclOut) begin lo++; @(negedge clk); end
    while (sclOut) begin hi++; @(negedge clk); end
    check("R3 low length", lo, (10 + 4 * g) * (d + 1));
    check("R4 high length", hi, (10 + 4 * g + COMP) * (d + 1));
  endtask

  task automatic countRefTicks(int window, int d);
    int n = 0;
    for (int i = 0; i < window; i++) begin
      @(negedge clk);
      if (refTick) n++;
    end
    check("R1 refTick rate", n, window / (d + 1));
  endtask

  initial begin
    int n;
    #(CLK_PERIOD * 3 + 1);
    // R8: reset state while enable is low
    check("R8 sclOut in reset", int'(sclOut), 1);
    check("R8 strobes in reset", int'({refTick, midLowTick, midHighTick, periodEnd}), 0);
    rstN = 1'b1;

    // R1/R2/R3/R4 across several settings
    drive(1'b1, mk(0, 0));
    measurePeriod(0, 0, "R2 period d0 g0");
    measurePhases(0, 0);
    drive(1'b0, mk(7, 0));
    drive(1'b1, mk(7, 0));
    countRefTicks(80, 7);
    measurePeriod(7, 0, "R2 period d7 g0");
    drive(1'b0, mk(1, 3));
    drive(1'b1, mk(1, 3));
    measurePeriod(1, 3, "R2 period d1 g3");
    measurePhases(1, 3);
    drive(1'b0, mk(0, 63));
    drive(1'b1, mk(0, 63));
    measurePeriod(0, 63, "R2 period d0 g63");

    // R6: change mid-run, old period must complete unchanged
    drive(1'b1, mk(2, 1));
    drive(1'b0, mk(2, 1));
    drive(1'b1, mk(2, 1));
    waitEnd();
    @(posedge clk); #1;
    cfgWord = mk(0, 2);
    toNextEnd(n);
    check("R6 current period keeps old config", n, periodOf(1) * 3);
    toNextEnd(n);
    check("R6 next period uses new config", n, periodOf(2) * 1);

    // R7: idle, words change, last idle word is used on start
    drive(1'b0, mk(5, 9));
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check("R7 idle sclOut high", int'(sclOut), 1);
      check("R7 idle no strobes", int'({refTick, midLowTick, midHighTick, periodEnd}), 0);
    end
    drive(1'b0, mk(3, 2));
    drive(1'b1, mk(3, 2));
    n = 0;
    @(negedge clk);
    check("R7 first cycle after enable low", int'(sclOut), 0);
    do begin n++; @(negedge clk); end while (!periodEnd);
    check("R7 first period from idle word", n + 1, periodOf(2) * 4);

    drive(1'b0, mk(0, 0));
    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule